// File: doc/BRIEF.md
# External Flash and Buffer SRAM Strobe Controller

This block connects a byte-wide internal request port to two external memories. One is a read-only program flash with a 15-bit address. The other is a read/write buffer SRAM with a 14-bit address and 8-bit data. A requester raises `req` with a target select, a direction, an address and write data. It holds them until the block returns a one-cycle `ack`. The block then drives the active-low chip select, enable, read and write strobes, and it steers the SRAM data bus through a separate output-enable. Read data is captured at the edge where the read strobe deasserts.

Every access has three phases: address setup, strobe low, and hold. Each phase length is a parameter, with one set of parameters for the flash and another for the SRAM. With the defaults of 1, 2 and 1 cycles on a 14.318 MHz clock (69.84 ns), all flash and SRAM minimum setup, pulse-width and hold times are met with margin. A write request aimed at the flash never reaches the pins. It is answered at once with `ack` and `err`.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: After reset, all chip selects, enables and strobes are high, `sr_doe` is 0, and `ack` and `err` are 0.
- R2: A flash read pulls `fl_cs_n` low with the address valid for one cycle before `fl_rd_n` falls. `fl_rd_n` then stays low for two cycles, and `fl_cs_n` and the address stay for one more cycle after it rises.
- R3: A flash read returns on `rdata`, together with `ack`, the byte that `fl_din` carried in the last cycle in which `fl_rd_n` was low.
- R4: An SRAM write (`req_sram`=1, `req_we`=1) pulls `sr_wr_n` low for two cycles. `sr_dout` holds the request data at the rising edge of `sr_wr_n`, and the memory stores it there.
- R5: An SRAM read pulls `sr_rd_n` low for two cycles. `rdata` returns the byte that `sr_din` carried in the last low cycle, even though the bus becomes invalid right after the strobe rises.
- R6: `sr_doe` is 1 only from address setup through hold of an SRAM write. It is 0 at all other times, including during every read.
- R7: A flash write (`req_sram`=0, `req_we`=1) gives `ack`=1 and `err`=1 one cycle after acceptance. No strobe and no chip select go low for it.
- R8: `sr_en_n` is low exactly during the setup, strobe and hold cycles of an SRAM access. `fl_cs_n` is low exactly during those cycles of a flash read. The two are never low together.
- R9: `ack` is a single-cycle pulse in the last hold cycle, four cycles after acceptance with the defaults. At most one of the three strobes is low at any time.
- R10: The address at the pins of the selected memory equals the request address and stays stable from setup through hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14.318 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request; held until `ack` |
| req_sram | input | 1 | Target: 1 selects the SRAM, 0 selects the flash |
| req_we | input | 1 | 1 requests a write |
| req_addr | input | 15 | Byte address; the SRAM uses the low 14 bits |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `ack`: request rejected |
| rdata | output | 8 | Captured read data, valid with `ack` |
| fl_addr | output | 15 | Flash address |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_rd_n | output | 1 | Flash read strobe, active low |
| fl_din | input | 8 | Flash data bus |
| sr_en_n | output | 1 | SRAM enable, active low |
| sr_addr | output | 14 | SRAM address |
| sr_rd_n | output | 1 | SRAM read strobe, active low |
| sr_wr_n | output | 1 | SRAM write strobe, active low |
| sr_dout | output | 8 | SRAM write data |
| sr_doe | output | 1 | Drive enable for `sr_dout` onto the SRAM bus |
| sr_din | input | 8 | SRAM data bus as read back |

## Verification
Two things fall on the same clock edge: the rise of a read strobe and the capture of the read byte. The memory stubs in the bench turn their data bus to a garbage value the moment the strobe goes high, so data captured one edge late shows up as a mismatch against the expected byte. The second coincidence is the end of an access and the arrival of the next request. The bench raises the next request in the cycle right after `ack`, with a new target and direction, and it checks that the new access starts from a clean setup cycle with the right latency. It also checks that the old address, strobe or bus drive does not carry over into the new access.

// File: rtl/xmem_pkg.sv
// Shared types of the external memory strobe controller.
package xmem_pkg;
    // Access phase, common to both memories.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_REJECT = 3'd4
    } phase_t;

    // Memory targeted by a request.
    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_SRAM  = 1'b1
    } tgt_t;
endpackage

// File: rtl/xmem_phase_seq.sv
// Phase sequencer: steps an accepted access through setup, strobe and hold.
// The phase lengths come from the flash or the SRAM parameter set, chosen by
// the latched target. A rejected request spends one cycle in PH_REJECT.
// Assumes: tgt is stable from the cycle after start until done; every length is >= 1.
module xmem_phase_seq
    import xmem_pkg::*;
#(
    parameter int FL_SETUP = 1,
    parameter int FL_STRB  = 2,
    parameter int FL_HOLD  = 1,
    parameter int SR_SETUP = 1,
    parameter int SR_STRB  = 2,
    parameter int SR_HOLD  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   reject,
    input  tgt_t   tgt,
    output phase_t phase,
    output logic   cap,
    output logic   done
);
    localparam int MAX_FL = (FL_SETUP > FL_STRB) ? ((FL_SETUP > FL_HOLD) ? FL_SETUP : FL_HOLD)
                                                 : ((FL_STRB > FL_HOLD) ? FL_STRB : FL_HOLD);
    localparam int MAX_SR = (SR_SETUP > SR_STRB) ? ((SR_SETUP > SR_HOLD) ? SR_SETUP : SR_HOLD)
                                                 : ((SR_STRB > SR_HOLD) ? SR_STRB : SR_HOLD);
    localparam int MAX_LEN = (MAX_FL > MAX_SR) ? MAX_FL : MAX_SR;
    localparam int CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    // Last count value of the current phase for the current target.
    always_comb begin
        int len;
        len = 1;
        unique case (phase_q)
            PH_SETUP:  len = (tgt == TGT_SRAM) ? SR_SETUP : FL_SETUP;
            PH_STROBE: len = (tgt == TGT_SRAM) ? SR_STRB  : FL_STRB;
            PH_HOLD:   len = (tgt == TGT_SRAM) ? SR_HOLD  : FL_HOLD;
            default:   len = 1;
        endcase
        last_cnt = CNT_W'(len - 1);
    end

    assign at_last = (cnt_q == last_cnt);

    // Phase and in-phase counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) phase_q <= reject ? PH_REJECT : PH_SETUP;
                end
                PH_SETUP, PH_STROBE, PH_HOLD: begin
                    if (at_last) begin
                        cnt_q   <= '0;
                        phase_q <= (phase_q == PH_SETUP)  ? PH_STROBE :
                                   (phase_q == PH_STROBE) ? PH_HOLD : PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q   <= '0;
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign phase = phase_q;
    assign cap   = (phase_q == PH_STROBE) && at_last;
    assign done  = ((phase_q == PH_HOLD) && at_last) || (phase_q == PH_REJECT);
endmodule

// File: rtl/xmem_rd_capture.sv
// Read capture register: stores the byte of the selected memory in the last
// strobe-low cycle, so the value taken is the one present at the strobe's rising edge.
// Assumes: cap is a single-cycle pulse from the phase sequencer.
module xmem_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          from_sram,
    input  logic [DW-1:0] fl_din,
    input  logic [DW-1:0] sr_din,
    output logic [DW-1:0] rdata
);
    // Capture on the strobe-release edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   rdata <= '0;
        else if (cap) rdata <= from_sram ? sr_din : fl_din;
    end
endmodule

// File: rtl/xmem_strobe_ctrl.sv
// External flash and buffer SRAM strobe controller (top).
// Takes a request only when idle, latches it, and decodes the pin strobes
// from the access phase. A flash write is answered with err and no strobe.
// Assumes: the requester holds req and its fields stable until ack.
module xmem_strobe_ctrl
    import xmem_pkg::*;
#(
    parameter int FL_AW    = 15,
    parameter int SR_AW    = 14,
    parameter int DW       = 8,
    parameter int FL_SETUP = 1,
    parameter int FL_STRB  = 2,
    parameter int FL_HOLD  = 1,
    parameter int SR_SETUP = 1,
    parameter int SR_STRB  = 2,
    parameter int SR_HOLD  = 1,
    localparam int RA_W    = (FL_AW > SR_AW) ? FL_AW : SR_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_sram,
    input  logic             req_we,
    input  logic [RA_W-1:0]  req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic             err,
    output logic [DW-1:0]    rdata,
    output logic [FL_AW-1:0] fl_addr,
    output logic             fl_cs_n,
    output logic             fl_rd_n,
    input  logic [DW-1:0]    fl_din,
    output logic             sr_en_n,
    output logic [SR_AW-1:0] sr_addr,
    output logic             sr_rd_n,
    output logic             sr_wr_n,
    output logic [DW-1:0]    sr_dout,
    output logic             sr_doe,
    input  logic [DW-1:0]    sr_din
);
    phase_t          phase;
    tgt_t            tgt_q;
    logic            we_q;
    logic [RA_W-1:0] addr_q;
    logic [DW-1:0]   wdata_q;
    logic            accept;
    logic            reject;
    logic            cap;
    logic            done;
    logic            in_access;
    logic            is_sram;
    logic            strobing;

    assign accept = req && (phase == PH_IDLE);
    assign reject = !req_sram && req_we;

    // Request latch, loaded when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= TGT_FLASH;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            tgt_q   <= req_sram ? TGT_SRAM : TGT_FLASH;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    xmem_phase_seq #(
        .FL_SETUP(FL_SETUP), .FL_STRB(FL_STRB), .FL_HOLD(FL_HOLD),
        .SR_SETUP(SR_SETUP), .SR_STRB(SR_STRB), .SR_HOLD(SR_HOLD)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .reject(reject),
        .tgt   (tgt_q),
        .phase (phase),
        .cap   (cap),
        .done  (done)
    );

    xmem_rd_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .from_sram(tgt_q == TGT_SRAM),
        .fl_din   (fl_din),
        .sr_din   (sr_din),
        .rdata    (rdata)
    );

    // Pin decode from the access phase and the latched request.
    always_comb begin
        in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        is_sram   = (tgt_q == TGT_SRAM);
        strobing  = (phase == PH_STROBE);
        fl_cs_n   = !(in_access && !is_sram);
        fl_rd_n   = !(strobing && !is_sram);
        sr_en_n   = !(in_access && is_sram);
        sr_rd_n   = !(strobing && is_sram && !we_q);
        sr_wr_n   = !(strobing && is_sram && we_q);
        sr_doe    = in_access && is_sram && we_q;
    end

    assign fl_addr = addr_q[FL_AW-1:0];
    assign sr_addr = addr_q[SR_AW-1:0];
    assign sr_dout = wdata_q;
    assign ack     = done;
    assign err     = (phase == PH_REJECT);
endmodule

// File: rtl/xmem_strobe_chk.sv
// Protocol checker for xmem_strobe_ctrl, attached by bind.
// Assumes: the pin outputs of the top are observed exactly as driven.
module xmem_strobe_chk #(
    parameter int FL_AW = 15,
    parameter int SR_AW = 14,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             err,
    input logic             fl_cs_n,
    input logic             fl_rd_n,
    input logic             sr_en_n,
    input logic             sr_rd_n,
    input logic             sr_wr_n,
    input logic             sr_doe,
    input logic [FL_AW-1:0] fl_addr,
    input logic [SR_AW-1:0] sr_addr,
    input logic [DW-1:0]    sr_dout
);
    // R9: never two strobes low together.
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!fl_rd_n, !sr_rd_n, !sr_wr_n}) <= 1);
    // R9: ack lasts one cycle.
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R2: the flash strobe falls only after a cycle of chip select.
    p_fl_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_rd_n) |-> $past(!fl_cs_n));
    // R2: chip select stays low one cycle after the strobe rises.
    p_fl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_rd_n) |-> !fl_cs_n);
    // R8: the two memories are never selected together.
    p_exclusive_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_cs_n && !sr_en_n));
    // R6: a driven bus never coincides with a read strobe; a write strobe has drive.
    p_bus_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_doe |-> sr_rd_n) and (!sr_wr_n |-> sr_doe));
    // R7: a rejected access selects nothing.
    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && err) |-> (fl_cs_n && sr_en_n && sr_doe == 1'b0));
    // R10: the SRAM address and write data stay still while the SRAM is enabled.
    p_sr_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_en_n && $past(!sr_en_n) && $past(rst_n)) |-> ($stable(sr_addr) && $stable(sr_dout)));
    // R10: the flash address stays still while the flash is selected.
    p_fl_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_cs_n && $past(!fl_cs_n) && $past(rst_n)) |-> $stable(fl_addr));
endmodule

bind xmem_strobe_ctrl xmem_strobe_chk #(.FL_AW(FL_AW), .SR_AW(SR_AW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (ack),
    .err    (err),
    .fl_cs_n(fl_cs_n),
    .fl_rd_n(fl_rd_n),
    .sr_en_n(sr_en_n),
    .sr_rd_n(sr_rd_n),
    .sr_wr_n(sr_wr_n),
    .sr_doe (sr_doe),
    .fl_addr(fl_addr),
    .sr_addr(sr_addr),
    .sr_dout(sr_dout)
);

// File: tb/xmem_strobe_ctrl_tb.sv
`timescale 1ns/10ps
module xmem_strobe_ctrl_tb;
    localparam real CLK_PERIOD = 69.84;
    localparam int  MW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_sram = 1'b0, req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack, err;
    logic [7:0]  rdata;
    logic [14:0] fl_addr;
    logic        fl_cs_n, fl_rd_n;
    logic [7:0]  fl_din;
    logic        sr_en_n;
    logic [13:0] sr_addr;
    logic        sr_rd_n, sr_wr_n;
    logic [7:0]  sr_dout;
    logic        sr_doe;
    logic [7:0]  sr_din;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] smem [MW];   // SRAM stub contents
    logic [7:0] emem [MW];   // expected contents
    logic       wr_rise_doe;
    logic [7:0] wr_rise_data;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    xmem_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_sram(req_sram), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .err(err), .rdata(rdata),
        .fl_addr(fl_addr), .fl_cs_n(fl_cs_n), .fl_rd_n(fl_rd_n), .fl_din(fl_din),
        .sr_en_n(sr_en_n), .sr_addr(sr_addr), .sr_rd_n(sr_rd_n), .sr_wr_n(sr_wr_n),
        .sr_dout(sr_dout), .sr_doe(sr_doe), .sr_din(sr_din)
    );

    function automatic logic [7:0] flash_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    // Stubs: data valid only while the strobe is low, garbage right after.
    assign fl_din = !fl_rd_n ? flash_byte(fl_addr) : 8'hEE;
    assign sr_din = !sr_rd_n ? smem[sr_addr[5:0]] : 8'hEE;

    always @(posedge sr_wr_n) begin
        wr_rise_doe  = sr_doe;
        wr_rise_data = sr_dout;
        smem[sr_addr[5:0]] = sr_dout;
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    // One access with the full pin-level checks against the requirements.
    task automatic access(input bit sram, input bit we, input logic [14:0] addr,
                          input logic [7:0] wd);
        int n = 0, flc = 0, src = 0, swc = 0, doe_bad = 0, sel_bad = 0, addr_bad = 0;
        bit got = 0, setup_ok = 0;
        logic [7:0] rd = '0;
        logic       er = 1'b0;
        bit rej = !sram && we;
        @(negedge clk);
        req = 1'b1; req_sram = sram; req_we = we; req_addr = addr; req_wdata = wd;
        wr_rise_doe = 1'b0;
        for (int i = 0; i < 10 && !got; i++) begin
            @(negedge clk);
            n++;
            if (!fl_rd_n) flc++;
            if (!sr_rd_n) src++;
            if (!sr_wr_n) swc++;
            if (sr_doe != (sram && we && !rej)) doe_bad++;
            if (rej ? (!fl_cs_n || !sr_en_n) : (sram ? (sr_en_n || !fl_cs_n) : (fl_cs_n || !sr_en_n)))
                sel_bad++;
            if (!rej && (sram ? (sr_addr != addr[13:0]) : (fl_addr != addr))) addr_bad++;
            if (n == 1) setup_ok = fl_rd_n && sr_rd_n && sr_wr_n;
            if (ack) begin
                got = 1; rd = rdata; er = err;
                req = 1'b0;
            end
        end
        if (!got) begin
            check(0, "R9", "no ack (timeout)", n, 4);
            return;
        end
        if (rej) begin
            check(n == 1 && er, "R7", "reject latency/err", {n, 4'(er)}, {32'd1, 4'd1});
            check(flc + src + swc + sel_bad == 0, "R7", "strobe or select on reject",
                  flc + src + swc + sel_bad, 0);
            return;
        end
        check(n == 4 && !er, "R9", "ack latency", n, 4);
        check(setup_ok, "R2", "strobe low in setup cycle", 0, 1);
        check(sel_bad == 0, "R8", "select window", sel_bad, 0);
        check(addr_bad == 0, "R10", "address at pins", addr_bad, 0);
        check(doe_bad == 0, "R6", "bus drive window", doe_bad, 0);
        if (!sram) begin
            check(flc == 2 && src + swc == 0, "R2", "flash strobe cycles", flc, 2);
            check(rd == flash_byte(addr), "R3", "flash rdata", rd, flash_byte(addr));
        end else if (we) begin
            check(swc == 2 && flc + src == 0, "R4", "write strobe cycles", swc, 2);
            check(wr_rise_doe && wr_rise_data == wd, "R4", "data at write rise",
                  wr_rise_data, wd);
            emem[addr[5:0]] = wd;
        end else begin
            check(src == 2 && flc + swc == 0, "R5", "read strobe cycles", src, 2);
            check(rd == emem[addr[5:0]], "R5", "sram rdata", rd, emem[addr[5:0]]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000.0);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MW; i++) begin
            smem[i] = 8'(i * 7 + 3);
            emem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(fl_cs_n && fl_rd_n && sr_en_n && sr_rd_n && sr_wr_n && !sr_doe && !ack && !err,
              "R1", "pins during reset", {fl_cs_n, fl_rd_n, sr_en_n, sr_rd_n, sr_wr_n, sr_doe, ack, err},
              8'b11111000);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_cs_n && fl_rd_n && sr_en_n && sr_rd_n && sr_wr_n && !sr_doe && !ack,
              "R1", "pins after reset", {fl_cs_n, fl_rd_n, sr_en_n, sr_rd_n, sr_wr_n, sr_doe, ack},
              7'b1111100);
        // Directed corners.
        access(1'b0, 1'b0, 15'h7FFF, 8'h00);     // R3 top flash address
        access(1'b0, 1'b0, 15'h0000, 8'h00);     // R3 bottom flash address
        access(1'b0, 1'b1, 15'h1234, 8'hA5);     // R7 flash write rejected
        check(rdata == flash_byte(15'h0000), "R7", "rdata untouched by reject",
              rdata, flash_byte(15'h0000));
        access(1'b1, 1'b1, 15'h0005, 8'hFF);     // R4
        access(1'b1, 1'b0, 15'h0005, 8'h00);     // R5 read back
        access(1'b1, 1'b1, 15'h3FC5, 8'h00);     // R4 top address, same low bits
        access(1'b1, 1'b0, 15'h0005, 8'h00);     // R5
        // Random mix; a new request follows each ack without a gap.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r = $urandom;
            logic [14:0] a = 15'($urandom);
            if (r[0]) a[14] = 1'b0;
            access(r[1], r[2] & (r[1] | r[3]), r[1] ? {1'b0, a[13:0]} : a, 8'($urandom));
            if (r[4] & r[5]) repeat (r[7:6]) @(negedge clk);
        end
        @(negedge clk);
        check(!sr_doe && sr_en_n && fl_cs_n, "R6", "bus released when idle", sr_doe, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule